// File: doc/BRIEF.md
# One-Shot PWM Timer Channel

This block is an up-counting timer with a single compare channel. It is aimed at making one timed pulse per external event. While the counter is idle, a rising edge on the trigger input arms the run flag. From then on, every prescaler tick advances the count from zero. When a tick arrives with the count at the reload value, the count returns to zero and a one-cycle update pulse is produced. In one-shot mode that same update also clears the run flag, so the counter sits at zero until the next trigger. In continuous mode the count keeps wrapping.

The channel output is a reference level formed by comparing the count with a compare register. There are two PWM polarities and two constant levels. The comparison result passes through a two-stage registered delay before it reaches the pin. A fast-start option removes that delay for trigger-started pulses: the output is driven to its post-match level on the trigger itself. A debug-halt input freezes the count, but only while the hold bit in the control register is set. Software programs the block through a small write-only register port. A write to the control register can also start the counter without a trigger.

Top module: `pulse_timer`

## Requirements
- R1: After reset, count is 0, running is 0, update_evt is 0 and ref_out is 0. The reload, compare and control registers all reset to 0.
- R2: A rising edge of trig_in that is sampled while running is 0 sets running at that clock edge. The count stays 0 until the next tick. A tick in the start cycle does not advance the count.
- R3: While running is 1 and the counter is not frozen, a clock with tick=1 advances the count by one. If the count already equals the reload value, that clock instead sets the count to 0 and raises update_evt for exactly one cycle.
- R4: Control bit 0 selects one-shot mode. With bit 0 = 1, the wrapping clock also clears running, and the count stays 0. With bit 0 = 0, running stays 1 across wraps.
- R5: A trigger rising edge while running is 1 has no effect on count or running. This includes the clock in which the one-shot wrap clears running.
- R6: Control bits [2:1] select the output mode: 00 constant low, 01 constant high, 10 PWM-A (high while count < compare, else low), 11 PWM-B (the inverse of PWM-A). Outside a forced interval, ref_out shows the mode result for the count held two clocks earlier. With compare = 4, ref_out in PWM-A falls six clocks after the trigger edge that starts the pulse.
- R7: Control bit 3 enables fast start. When this bit is set in PWM-A or PWM-B mode, a trigger that starts the counter forces ref_out to its post-match level, from the start edge onward. The post-match level is 0 for PWM-A and 1 for PWM-B. The force ends at the first clock where the delayed compare result has reached that level, or where running is 0 or a non-PWM mode is selected.
- R8: Fast start has no effect when the counter is started by software: a control write with bit 5 = 1, issued while running is 0. Fast start also has no effect in the constant-level modes.
- R9: With dbg_halt = 1 and control bit 4 (hold) = 1, ticks do not change count or running. With hold = 0, dbg_halt has no effect.
- R10: A write with wr_en = 1 takes effect at the clock edge. Address 0 selects the reload value, address 1 the compare value, and address 2 the control bits [4:0]. Control bit 5 is a start strobe and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescaler clock enable for the counter |
| trig_in | input | 1 | External start trigger, rising edge active |
| dbg_halt | input | 1 | Debug halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 compare, 2 control |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| running | output | 1 | Counter enable state |
| update_evt | output | 1 | One-cycle pulse on each wrap |
| ref_out | output | 1 | Channel reference output |

## Verification
Two events can fall in the same cycle: a trigger rising edge and the one-shot wrap that stops the counter. The bench sets a short reload and times the trigger edge to coincide with the wrapping clock. It expects running to stay 0 afterwards, because the trigger was sampled while the counter was still running. A second collision is between the fast-start force and a natural match. Random runs cover it with compare values of 0 and values beyond the reload. A cycle model built from the requirements predicts when the force should release, and every output is compared against that model on every cycle.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

  typedef enum logic [1:0] {
    OUT_LOW   = 2'b00,
    OUT_HIGH  = 2'b01,
    OUT_PWM_A = 2'b10,
    OUT_PWM_B = 2'b11
  } chan_mode_e;

  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_CMP    = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTL_ONESHOT = 0;
  localparam int CTL_MODE_LO = 1;
  localparam int CTL_FAST    = 3;
  localparam int CTL_HOLD    = 4;
  localparam int CTL_GO      = 5;

  typedef struct packed {
    logic       hold;
    logic       fast;
    chan_mode_e mode;
    logic       oneshot;
  } ctrl_t;

endpackage

// File: rtl/pulse_timer_regs.sv
module pulse_timer_regs
  import pulse_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload,
  output logic [W-1:0] cmp,
  output ctrl_t        ctrl,
  output logic         sw_go
);

  logic [W-1:0] reload_d, cmp_d;
  ctrl_t        ctrl_d;

  always_comb begin
    reload_d = reload;
    cmp_d    = cmp;
    ctrl_d   = ctrl;
    sw_go    = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_RELOAD: reload_d = wr_data;
        ADDR_CMP:    cmp_d    = wr_data;
        ADDR_CTRL: begin
          ctrl_d.oneshot = wr_data[CTL_ONESHOT];
          ctrl_d.mode    = chan_mode_e'(wr_data[CTL_MODE_LO +: 2]);
          ctrl_d.fast    = wr_data[CTL_FAST];
          ctrl_d.hold    = wr_data[CTL_HOLD];
          sw_go          = wr_data[CTL_GO];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reload <= '0;
      cmp    <= '0;
      ctrl   <= '0;
    end else begin
      reload <= reload_d;
      cmp    <= cmp_d;
      ctrl   <= ctrl_d;
    end
  end

  // R10: a control write lands on the next edge
  a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en && (wr_addr == ADDR_CTRL) |=> ctrl.mode == $past(wr_data[CTL_MODE_LO +: 2]));

endmodule

// File: rtl/pulse_timer_counter.sv
module pulse_timer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick,
  input  logic         halt_req,
  input  logic         hold_en,
  input  logic         trig_in,
  input  logic         sw_go,
  input  logic         oneshot,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         run,
  output logic         upd,
  output logic         hw_start
);

  logic         trig_q;
  logic         trig_rise, frozen, adv, at_top, wrap;
  logic [W-1:0] cnt_d;
  logic         run_d;

  always_comb begin
    trig_rise = trig_in & ~trig_q;
    frozen    = halt_req & hold_en;
    adv       = run & tick & ~frozen;
    at_top    = (cnt == reload);
    wrap      = adv & at_top;
    hw_start  = ~run & trig_rise;
    cnt_d     = cnt;
    if (adv) cnt_d = at_top ? '0 : cnt + 1'b1;
    if (run) run_d = ~(wrap & oneshot);
    else     run_d = hw_start | sw_go;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cnt    <= '0;
      run    <= 1'b0;
      upd    <= 1'b0;
    end else begin
      trig_q <= trig_in;
      cnt    <= cnt_d;
      run    <= run_d;
      upd    <= wrap;
    end
  end

  // R2: trigger edge while idle starts the counter
  a_r2_trig_start: assert property (@(posedge clk) disable iff (!rst_ni)
    !run && trig_in && !trig_q |=> run);

  // R3: a tick below the reload value steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_ni)
    run && tick && !frozen && (cnt != reload) |=> cnt == $past(cnt) + 1'b1);

  // R4: one-shot wrap stops the counter at zero
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_ni)
    run && tick && !frozen && (cnt == reload) && oneshot |=> !run && (cnt == '0) && upd);

  // R5: nothing but a one-shot wrap ends a run, whatever the trigger does
  a_r5_keep_running: assert property (@(posedge clk) disable iff (!rst_ni)
    run && !(tick && !frozen && (cnt == reload) && oneshot) |=> run);

  // R9: frozen counter holds its value
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_ni)
    halt_req && hold_en |=> $stable(cnt));

endmodule

// File: rtl/pulse_timer_channel.sv
module pulse_timer_channel
  import pulse_timer_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  chan_mode_e   mode,
  input  logic         fast,
  input  logic         run,
  input  logic         hw_start,
  output logic         ref_out
);

  logic           raw;
  logic [LAT-1:0] dly, dly_d;
  logic           frc, frc_d;
  logic           flvl, flvl_d;
  logic           below;
  logic           dly_last;

  always_comb begin
    below = (cnt < cmp);
    unique case (mode)
      OUT_LOW:   raw = 1'b0;
      OUT_HIGH:  raw = 1'b1;
      OUT_PWM_A: raw = below;
      OUT_PWM_B: raw = ~below;
      default:   raw = 1'b0;
    endcase
  end

  generate
    if (LAT == 1) begin : g_one
      always_comb dly_d = raw;
    end else begin : g_chain
      always_comb dly_d = {dly[LAT-2:0], raw};
    end
  endgenerate

  assign dly_last = dly[LAT-1];

  always_comb begin
    frc_d  = frc;
    flvl_d = flvl;
    if (hw_start && fast && mode[1]) begin
      frc_d  = 1'b1;
      flvl_d = mode[0];
    end else if (!run || (dly_last == flvl) || !mode[1]) begin
      frc_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dly  <= '0;
      frc  <= 1'b0;
      flvl <= 1'b0;
    end else begin
      dly  <= dly_d;
      frc  <= frc_d;
      flvl <= flvl_d;
    end
  end

  assign ref_out = frc ? flvl : dly_last;

  // R7: fast trigger start drives the post-match level at once
  a_r7_fast_force: assert property (@(posedge clk) disable iff (!rst_ni)
    hw_start && fast && mode[1] |=> ref_out == $past(mode[0]));

  // R8: only a trigger start can begin a forced interval
  a_r8_force_source: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(frc) |-> $past(hw_start && fast && mode[1]));

  generate
    if (LAT == 2) begin : g_lat_chk
      // R6: unforced output follows the mode result two clocks late
      a_r6_latency: assert property (@(posedge clk) disable iff (!rst_ni)
        !frc |-> ref_out == $past(raw, 2));
    end
  endgenerate

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig_in,
  input  logic             dbg_halt,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             update_evt,
  output logic             ref_out
);

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [CNT_W-1:0] reload, cmp;
  ctrl_t            ctrl;
  logic             sw_go, hw_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  pulse_timer_regs #(.W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .reload  (reload),
    .cmp     (cmp),
    .ctrl    (ctrl),
    .sw_go   (sw_go)
  );

  pulse_timer_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .tick     (tick),
    .halt_req (dbg_halt),
    .hold_en  (ctrl.hold),
    .trig_in  (trig_in),
    .sw_go    (sw_go),
    .oneshot  (ctrl.oneshot),
    .reload   (reload),
    .cnt      (count),
    .run      (running),
    .upd      (update_evt),
    .hw_start (hw_start)
  );

  pulse_timer_channel #(.W(CNT_W), .LAT(LAT)) u_chan (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .cnt      (count),
    .cmp      (cmp),
    .mode     (ctrl.mode),
    .fast     (ctrl.fast),
    .run      (running),
    .hw_start (hw_start),
    .ref_out  (ref_out)
  );

  // R1: reset leaves the block idle
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ni |=> !update_evt);

endmodule

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, trig, halt, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count;
  logic        running, update_evt, ref_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig), .dbg_halt(halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .running(running), .update_evt(update_evt), .ref_out(ref_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic f_raw(input logic [1:0] mode, input logic [15:0] c, input logic [15:0] k);
    case (mode)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return c < k;
      default: return !(c < k);
    endcase
  endfunction

  // cycle model written from the requirements
  logic [15:0] m_rel, m_cmp, m_cnt;
  logic [4:0]  m_ctl;
  logic        m_run, m_upd, m_trq, m_frc, m_flvl, m_d1, m_d2;

  always @(posedge clk or negedge rst_n) begin : model
    logic rise, frz, adv, wrap, hw, sw, raw;
    logic [1:0] md;
    if (!rst_n) begin
      m_rel = 0; m_cmp = 0; m_cnt = 0; m_ctl = 0;
      m_run = 0; m_upd = 0; m_trq = 0; m_frc = 0; m_flvl = 0; m_d1 = 0; m_d2 = 0;
    end else begin
      md   = m_ctl[2:1];
      rise = trig && !m_trq;
      frz  = halt && m_ctl[4];
      adv  = m_run && tick && !frz;
      wrap = adv && (m_cnt == m_rel);
      hw   = !m_run && rise;
      sw   = wr_en && (wr_addr == 2'd2) && wr_data[5];
      raw  = f_raw(md, m_cnt, m_cmp);
      if (hw && m_ctl[3] && md[1]) begin m_frc = 1; m_flvl = md[0]; end
      else if (!m_run || (m_d2 == m_flvl) || !md[1]) m_frc = 0;
      if (m_run) m_run = !(wrap && m_ctl[0]);
      else       m_run = hw || sw;
      if (adv) m_cnt = wrap ? 16'd0 : m_cnt + 16'd1;
      m_upd = wrap;
      m_d2  = m_d1;
      m_d1  = raw;
      m_trq = trig;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_rel = wr_data;
          2'd1: m_cmp = wr_data;
          2'd2: m_ctl = wr_data[4:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R3 count vs model", count, m_cnt);
      chk("R2 running vs model", {15'd0, running}, {15'd0, m_run});
      chk("R3 update vs model", {15'd0, update_evt}, {15'd0, m_upd});
      chk("R6 ref vs model", {15'd0, ref_out}, {15'd0, m_frc ? m_flvl : m_d2});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_trig();
    trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (running && n < 300) begin @(negedge clk); n++; end
    chk(tag, {15'd0, running}, 16'd0);
  endtask

  initial begin
    int k;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; tick = 0; trig = 0; halt = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 count", count, 16'd0);
    chk("R1 running", {15'd0, running}, 16'd0);
    chk("R1 update", {15'd0, update_evt}, 16'd0);
    chk("R1 ref", {15'd0, ref_out}, 16'd0);
    chk_on = 1;
    tick = 1;

    // reference pulse: reload 0x60, compare 4, PWM-A, one-shot
    wr(2'd0, 16'h0060);
    wr(2'd1, 16'h0004);
    wr(2'd2, 16'h0005);
    repeat (3) @(negedge clk);
    chk("R6 PWM-A idle level", {15'd0, ref_out}, 16'd1);
    pulse_trig();
    chk("R2 started", {15'd0, running}, 16'd1);
    chk("R2 count held at start", count, 16'd0);
    k = 0;
    while (ref_out !== 1'b0 && k < 20) begin @(negedge clk); k++; end
    chk("R6 compare latency", k[15:0], 16'd6);
    repeat (16'h61 - 7) @(negedge clk);
    chk("R3 count at reload", count, 16'h0060);
    chk("R4 still running at reload", {15'd0, running}, 16'd1);
    @(negedge clk);
    chk("R4 one-shot stop", {15'd0, running}, 16'd0);
    chk("R3 wrap to zero", count, 16'd0);
    chk("R3 update pulse", {15'd0, update_evt}, 16'd1);
    @(negedge clk);
    chk("R3 update one cycle", {15'd0, update_evt}, 16'd0);
    repeat (3) @(negedge clk);

    // fast start by trigger
    wr(2'd2, 16'h000D);
    repeat (3) @(negedge clk);
    pulse_trig();
    chk("R7 fast forced low on trigger", {15'd0, ref_out}, 16'd0);
    wait_idle("R4 fast pulse ends");
    repeat (3) @(negedge clk);

    // software start with fast set: no forcing
    wr(2'd2, 16'h002D);
    chk("R8 sw start runs", {15'd0, running}, 16'd1);
    chk("R8 sw start keeps pre level", {15'd0, ref_out}, 16'd1);
    repeat (2) @(negedge clk);
    chk("R8 pre level before match", {15'd0, ref_out}, 16'd1);
    wait_idle("R4 sw pulse ends");

    // fast in constant-high mode: no effect
    wr(2'd2, 16'h000B);
    repeat (3) @(negedge clk);
    pulse_trig();
    chk("R8 constant mode ignores fast", {15'd0, ref_out}, 16'd1);
    wait_idle("R4 const pulse ends");

    // retrigger during run ignored
    wr(2'd2, 16'h0005);
    pulse_trig();
    repeat (10) @(negedge clk);
    chk("R5 count before retrigger", count, 16'd10);
    pulse_trig();
    chk("R5 retrigger ignored", count, 16'd11);
    chk("R5 still running", {15'd0, running}, 16'd1);
    wait_idle("R4 retrigger pulse ends");

    // trigger on the stopping edge
    wr(2'd0, 16'd5);
    pulse_trig();
    repeat (5) @(negedge clk);
    pulse_trig();
    chk("R5 trigger at wrap ignored", {15'd0, running}, 16'd0);
    chk("R5 count zero after wrap", count, 16'd0);
    @(negedge clk);
    chk("R5 stays stopped", {15'd0, running}, 16'd0);

    // freeze with hold
    wr(2'd0, 16'h0060);
    wr(2'd2, 16'h0015);
    pulse_trig();
    repeat (3) @(negedge clk);
    halt = 1;
    repeat (5) @(negedge clk);
    chk("R9 frozen count", count, 16'd3);
    chk("R9 frozen running", {15'd0, running}, 16'd1);
    halt = 0;
    repeat (2) @(negedge clk);
    chk("R9 resumes", count, 16'd5);
    wr(2'd2, 16'h0005);
    chk("R10 ctrl write edge", count, 16'd6);
    halt = 1;
    repeat (4) @(negedge clk);
    chk("R9 halt without hold", count, 16'd10);
    halt = 0;
    wait_idle("R4 freeze pulse ends");

    // continuous PWM-B
    wr(2'd0, 16'd7);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0026);
    repeat (20) @(negedge clk);
    chk("R4 continuous keeps running", {15'd0, running}, 16'd1);
    wr(2'd2, 16'h0007);
    wait_idle("R4 one-shot after continuous");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom % 4) != 0;
      trig = ($urandom % 6) == 0;
      halt = ($urandom % 8) == 0;
      if (($urandom % 24) == 0) begin
        wr_en = 1;
        wr_addr = 2'($urandom % 3);
        case (wr_addr)
          2'd0: wr_data = 16'($urandom % 16);
          2'd1: wr_data = 16'($urandom % 18);
          default: wr_data = 16'($urandom % 64);
        endcase
      end else begin
        wr_en = 0;
      end
      @(negedge clk);
    end
    wr_en = 0; trig = 0; halt = 0;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule